// File: doc/BRIEF.md
# Successive-Approximation Converter Control and Parallel Bus Interface

This block is the digital control side of a sampling converter with a shared parallel data bus. A falling edge on the active-low convert-start input freezes the incoming raw sample and starts a conversion. The busy output (active low) stays low for a fixed, parameterised number of clock cycles, while a bit-serial successive-approximation engine settles the result. The finished code then enters a result register under one of two policies. In the first, the register is loaded at the end of conversion. In the second, the code is parked and only copied across at the next accepted start edge, so a read always returns the sample before the latest one.

The data bus is bidirectional. It is driven only while chip select and read are both low. When chip select is low, the falling edge of a high pulse on the write strobe captures the bus word as an offset value, which goes to a separate formatter. An active-low synchronous reset aborts a conversion, clears the offset and keeps the block idle while it is held. If a read arrives during a conversion, it returns the unchanged register and sets a sticky error flag.

All inputs are assumed to be synchronous to `clk`.

Top module: `sar_bus_ctrl`

## Requirements
- R1: A convert-start edge is the first clock edge that samples `cnv_n` low after it was sampled high. If `busy_n` is high at that edge, `busy_n` goes low after the edge. It stays low for exactly CONV_CYC clock cycles (default 30) and then returns high.
- R2: The conversion result equals the `raw_code` value sampled at the start edge. Changes on `raw_code` during the conversion have no effect on it.
- R3: With `mode_sel` = 2'b01, the result register is loaded at the same clock edge at which `busy_n` returns high.
- R4: With `mode_sel` = 2'b10, `busy_n` returns high but the result register keeps its old value. The held code is copied into the register at the next accepted start edge.
- R5: `data` is driven only while `cs_n` and `rd_n` are both low. It then carries the result register, with bit 14 always 0 and bits 13:0 holding the code. At all other times the bus is released.
- R6: A falling edge of `wr` with `cs_n` low captures `data` into `ofs_word`, visible one cycle after the edge that samples `wr` low. The same pulse with `cs_n` high leaves `ofs_word` unchanged.
- R7: While `rst_n` is low: `busy_n` is 1, `ofs_word` is 0, `rd_err` is 0, and the result register is 0. A conversion in progress is abandoned.
- R8: A start edge seen while `busy_n` is low is ignored. It neither restarts nor lengthens the conversion.
- R9: A read (`cs_n` and `rd_n` low) at a clock edge during a conversion returns the unchanged result register. `rd_err` goes to 1 after that edge and stays at 1 until reset.
- R10: The reserved `mode_sel` values 2'b00 and 2'b11 behave like 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; aborts a conversion |
| cnv_n | input | 1 | Convert start, falling edge active |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr | input | 1 | Write strobe; the falling edge of a high pulse latches the offset |
| mode_sel | input | 2 | Result update policy: 01 at end of conversion, 10 deferred |
| raw_code | input | 14 | Raw converter sample from the analog model |
| data | inout | 15 | Shared parallel data bus |
| busy_n | output | 1 | Low while a conversion runs |
| ofs_word | output | 15 | Latched offset word for the formatter |
| rd_err | output | 1 | Sticky flag: read attempted during a conversion |

## Verification
The timing of each result is as follows:
- `busy_n` falls one cycle after the edge that samples `cnv_n` low and rises CONV_CYC cycles later.
- In mode 01, the result register changes on that same rising edge of `busy_n`.
- In mode 10, the result register changes only on the next accepted start edge.
- `ofs_word` and `rd_err` change one cycle after the edge that samples the strobe.
- The bus follows `cs_n` and `rd_n` combinationally.

The bench drives inputs on the falling clock edge. Its reference model updates on the rising edge from the same sampled inputs. Every output is compared one time step after each falling edge, so each comparison falls inside the cycle in which the result is due.

// File: rtl/sar_bus_pkg.sv
// Package: shared encodings for the converter control block.
// Assumes: mode selection is a two-bit code on a static input.
package sar_bus_pkg;
    typedef enum logic [1:0] {
        MD_RSV_LO = 2'b00,
        MD_EOC    = 2'b01,
        MD_DEFER  = 2'b10,
        MD_RSV_HI = 2'b11
    } upd_mode_e;

    // Deferred policy is selected only by its exact code; reserved codes fall back (R10).
    function automatic logic is_defer(input logic [1:0] m);
        return m == MD_DEFER;
    endfunction
endpackage

// File: rtl/fall_det.sv
// Module: registered falling-edge detector for a synchronous level input.
// Assumes: the input is already synchronous to clk; IDLE is its resting level.
module fall_det #(
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fell
);
    logic prev_q;

    // Remember last sampled level so a high-to-low step can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= lvl;
    end

    assign fell = prev_q & ~lvl;
endmodule

// File: rtl/sar_core.sv
// Module: conversion timer plus behavioural bit-serial approximation engine.
// Assumes: CONV_CYC > RES_W so all bits settle before the timer expires.
module sar_core #(
    parameter int RES_W    = 14,
    parameter int CONV_CYC = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [RES_W-1:0] raw,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result
);
    localparam int CW = $clog2(CONV_CYC + 1);
    localparam int BW = (RES_W > 1) ? $clog2(RES_W) : 1;

    logic             busy_q, bit_act_q;
    logic [CW-1:0]    cnt_q;
    logic [BW-1:0]    bit_q;
    logic [RES_W-1:0] held_q, acc_q, trial;

    initial assert (CONV_CYC > RES_W) else $error("CONV_CYC must exceed RES_W");

    // Candidate code: accepted bits plus the bit now under test.
    always_comb trial = acc_q | (RES_W'(1) << bit_q);

    // Hold the sample, run the timer and decide one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            bit_act_q <= 1'b0;
            cnt_q     <= '0;
            bit_q     <= '0;
            held_q    <= '0;
            acc_q     <= '0;
        end else if (start && !busy_q) begin
            busy_q    <= 1'b1;
            cnt_q     <= CW'(CONV_CYC - 1);
            held_q    <= raw;
            acc_q     <= '0;
            bit_q     <= BW'(RES_W - 1);
            bit_act_q <= 1'b1;
        end else if (busy_q) begin
            if (bit_act_q) begin
                if (held_q >= trial) acc_q <= trial;
                if (bit_q == '0) bit_act_q <= 1'b0;
                else             bit_q     <= bit_q - 1'b1;
            end
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy   = busy_q;
    assign done   = busy_q && (cnt_q == '0);
    assign result = acc_q;

    // R2: search has converged on the held sample when the timer ends.
    a_r2_sar_settles: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc_q == held_q));
    // R8: a start edge mid-conversion only lets the timer keep counting down.
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sar_outreg.sv
// Module: result register with end-of-conversion and deferred update policies.
// Assumes: done is a single-cycle pulse; start_acc only fires when idle.
module sar_outreg #(
    parameter int RES_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic             start_acc,
    input  logic             defer,
    input  logic [RES_W-1:0] result,
    output logic [RES_W:0]   out_q
);
    logic [RES_W:0] pend_q;
    logic           pvld_q;

    // Load now, park for later, or release the parked code on a new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            pend_q <= '0;
            pvld_q <= 1'b0;
        end else if (done) begin
            if (defer) begin
                pend_q <= {1'b0, result};
                pvld_q <= 1'b1;
            end else begin
                out_q  <= {1'b0, result};
            end
        end else if (start_acc && pvld_q) begin
            out_q  <= pend_q;
            pvld_q <= 1'b0;
        end
    end

    // R3: immediate policy puts the finished code in the register.
    a_r3_eoc_load: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !defer) |=> (out_q == {1'b0, $past(result)}));
    // R4: deferred policy leaves the register alone at end of conversion.
    a_r4_defer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && defer) |=> $stable(out_q));
endmodule

// File: rtl/sar_busif.sv
// Module: tri-state bus drive, offset capture and read-protocol flag.
// Assumes: strobes are synchronous; the host never drives data while reading.
module sar_busif #(
    parameter int BUS_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr,
    input  logic             busy,
    input  logic [BUS_W-1:0] out_q,
    inout  wire  [BUS_W-1:0] data,
    output logic [BUS_W-1:0] ofs_q,
    output logic             err_q
);
    logic rd_act, wr_fell;

    fall_det #(.IDLE(1'b0)) u_wr_fd (.clk(clk), .rst_n(rst_n), .lvl(wr), .fell(wr_fell));

    assign rd_act = ~cs_n & ~rd_n;
    assign data   = rd_act ? out_q : {BUS_W{1'bz}};

    // Capture the offset word on a selected write strobe's trailing edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                ofs_q <= '0;
        else if (wr_fell && !cs_n) ofs_q <= data;
    end

    // Flag any read attempted while the converter is busy; sticky until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)            err_q <= 1'b0;
        else if (rd_act && busy) err_q <= 1'b1;
    end

    // R6: selected write captures the bus word.
    a_r6_ofs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fell && !cs_n) |=> (ofs_q == $past(data)));
    // R6: unselected write leaves the offset alone.
    a_r6_ofs_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fell && cs_n) |=> $stable(ofs_q));
    // R9: read during conversion raises the flag.
    a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && busy) |=> err_q);
    // R9: flag is sticky.
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    // R7: reset clears offset and flag.
    a_r7_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ofs_q == '0 && !err_q));
endmodule

// File: rtl/sar_bus_ctrl.sv
// Module: top of the converter control block; ties start detection, the
// approximation engine, the result register and the bus interface together.
// Assumes: all control inputs are synchronous to clk; mode_sel is static
// around each end of conversion.
module sar_bus_ctrl #(
    parameter int RES_W    = 14,
    parameter int CONV_CYC = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnv_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr,
    input  logic [1:0]       mode_sel,
    input  logic [RES_W-1:0] raw_code,
    inout  wire  [RES_W:0]   data,
    output logic             busy_n,
    output logic [RES_W:0]   ofs_word,
    output logic             rd_err
);
    import sar_bus_pkg::*;

    localparam int BUS_W = RES_W + 1;
    localparam int LW    = $clog2(CONV_CYC + 2);

    logic             cnv_fell, busy, done;
    logic [RES_W-1:0] result;
    logic [BUS_W-1:0] out_q;
    logic [LW-1:0]    low_cnt;

    fall_det #(.IDLE(1'b1)) u_cnv_fd (.clk(clk), .rst_n(rst_n), .lvl(cnv_n), .fell(cnv_fell));

    sar_core #(.RES_W(RES_W), .CONV_CYC(CONV_CYC)) u_core (
        .clk(clk), .rst_n(rst_n), .start(cnv_fell), .raw(raw_code),
        .busy(busy), .done(done), .result(result));

    sar_outreg #(.RES_W(RES_W)) u_oreg (
        .clk(clk), .rst_n(rst_n), .done(done), .start_acc(cnv_fell && !busy),
        .defer(is_defer(mode_sel)), .result(result), .out_q(out_q));

    sar_busif #(.BUS_W(BUS_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr(wr),
        .busy(busy), .out_q(out_q), .data(data), .ofs_q(ofs_word), .err_q(rd_err));

    assign busy_n = ~busy;

    // Checker counter: cycles busy_n has been sampled low in the current run.
    always_ff @(posedge clk) begin
        if (!rst_n)      low_cnt <= '0;
        else if (!busy_n) low_cnt <= low_cnt + 1'b1;
        else             low_cnt <= '0;
    end

    // R1: busy_n falls after an idle start edge.
    a_r1_busy_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_fell && busy_n) |=> !busy_n);
    // R1: an uninterrupted conversion lasts exactly CONV_CYC cycles.
    a_r1_busy_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_n) && $past(rst_n)) |-> (low_cnt == LW'(CONV_CYC)));
endmodule

// File: tb/sim_sar_bus_ctrl.sv
module sim_sar_bus_ctrl;
    localparam int RES_W = 14;
    localparam int BW    = RES_W + 1;
    localparam int CONV  = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0, cnv_n = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr = 1'b0;
    logic [1:0] mode_sel = 2'b01;
    logic [RES_W-1:0] raw_code = '0;
    logic tb_en = 1'b0;
    logic [BW-1:0] tb_val = '0;
    wire  [BW-1:0] bus;
    logic busy_n, rd_err;
    logic [BW-1:0] ofs_word;

    assign bus = tb_en ? tb_val : {BW{1'bz}};

    sar_bus_ctrl #(.RES_W(RES_W), .CONV_CYC(CONV)) u0 (
        .clk(clk), .rst_n(rst_n), .cnv_n(cnv_n), .cs_n(cs_n), .rd_n(rd_n), .wr(wr),
        .mode_sel(mode_sel), .raw_code(raw_code), .data(bus), .busy_n(busy_n),
        .ofs_word(ofs_word), .rd_err(rd_err));

    always #2 clk = ~clk;   // 250 MHz

    int n_chk = 0, n_fail = 0;
    bit started = 0, finished = 0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on every rising edge.
    bit m_busy, m_pvld, m_err, p_cnv, p_wr, fc, fw;
    int m_cnt;
    logic [BW-1:0] m_out, m_pend, m_ofs, m_held;
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_busy = 0; m_pvld = 0; m_err = 0; m_cnt = 0;
            m_out = 0; m_pend = 0; m_ofs = 0; m_held = 0; p_cnv = 1; p_wr = 0;
        end else begin
            fc = p_cnv && !cnv_n;
            fw = p_wr && !wr;
            if (!cs_n && !rd_n && m_busy) m_err = 1;
            if (fw && !cs_n) m_ofs = bus;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0;
                    if (mode_sel == 2'b10) begin m_pend = m_held; m_pvld = 1; end
                    else m_out = m_held;
                end
            end else if (fc) begin
                if (m_pvld) begin m_out = m_pend; m_pvld = 0; end
                m_busy = 1; m_cnt = CONV; m_held = {1'b0, raw_code};
            end
            p_cnv = cnv_n; p_wr = wr;
        end
    end

    // Per-cycle comparison, just after each falling edge.
    always @(negedge clk) begin
        #1;
        if (started && !finished) begin
            chk("R1 busy_n", busy_n, !m_busy);
            chk("R6 ofs_word", ofs_word, m_ofs);
            chk("R9 rd_err", rd_err, m_err);
            if (!cs_n && !rd_n) chk("R5 bus read", bus, m_out);
            else if (tb_en)     chk("R5 bus released", bus, tb_val);
        end
    end

    task automatic start_conv(input logic [RES_W-1:0] v);
        @(negedge clk); raw_code = v; cnv_n = 1'b0;
        @(negedge clk); cnv_n = 1'b1;
    endtask
    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic read_bus(output logic [BW-1:0] v);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1 v = bus;
        @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
    endtask
    task automatic write_ofs(input logic [BW-1:0] v, input logic sel_n);
        @(negedge clk); tb_en = 1'b1; tb_val = v; cs_n = sel_n; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        @(negedge clk); tb_en = 1'b0; cs_n = 1'b1;
    endtask

    initial begin : main
        logic [BW-1:0] v;
        int low;
        wait_cyc(3);
        chk("R7 reset busy_n", busy_n, 1'b1);
        chk("R7 reset ofs", ofs_word, '0);
        @(negedge clk); rst_n = 1'b1;
        read_bus(v); chk("R7 reset result", v, '0);

        // R3/R2: immediate mode, sample held while raw_code moves.
        mode_sel = 2'b01;
        start_conv(14'h1234); raw_code = 14'h0555;
        wait_cyc(CONV);
        read_bus(v); chk("R2 R3 held result", v, 15'h1234);

        // R1/R8: busy width measured with a second start edge inside it.
        start_conv(14'h3FFF);
        low = 1;
        wait_cyc(5); cnv_n = 1'b0; @(negedge clk); cnv_n = 1'b1; low += 6;
        while (!busy_n) begin @(negedge clk); low++; end
        chk("R8 R1 busy low cycles", low, CONV + 1);
        read_bus(v); chk("R5 top code bit14 zero", v, 15'h3FFF);

        // R5: bus released when not reading; host value seen.
        @(negedge clk); tb_en = 1'b1; tb_val = 15'h5A5A; cs_n = 1'b0;
        #1 chk("R5 released while rd_n high", bus, 15'h5A5A);
        @(negedge clk); tb_en = 1'b0; cs_n = 1'b1;

        // R6: selected write latches, unselected write ignored.
        write_ofs(15'h7ABC, 1'b0); @(negedge clk);
        chk("R6 offset latched", ofs_word, 15'h7ABC);
        write_ofs(15'h0101, 1'b1); @(negedge clk);
        chk("R6 unselected write ignored", ofs_word, 15'h7ABC);

        // R4: deferred mode returns the previous sample.
        mode_sel = 2'b10;
        start_conv(14'h0000); wait_cyc(CONV);
        read_bus(v); chk("R4 deferred keeps old", v, 15'h3FFF);
        start_conv(14'h2222); wait_cyc(CONV);
        read_bus(v); chk("R4 deferred copy on start", v, 15'h0000);
        start_conv(14'h0001); wait_cyc(CONV);
        read_bus(v); chk("R4 deferred next", v, 15'h2222);

        // R10: reserved code acts as immediate; parked code released first.
        mode_sel = 2'b11;
        start_conv(14'h0ABC); wait_cyc(CONV);
        read_bus(v); chk("R10 reserved immediate", v, 15'h0ABC);

        // R9: read while busy returns old data and sets sticky flag.
        start_conv(14'h1111); wait_cyc(3);
        read_bus(v); chk("R9 read during busy data", v, 15'h0ABC);
        chk("R9 flag set", rd_err, 1'b1);
        wait_cyc(CONV); chk("R9 flag sticky", rd_err, 1'b1);

        // R7: reset mid-conversion aborts and clears.
        start_conv(14'h0F0F); wait_cyc(4);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); chk("R7 abort busy_n", busy_n, 1'b1);
        chk("R7 abort ofs", ofs_word, '0);
        chk("R7 abort flag", rd_err, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        read_bus(v); chk("R7 abort result", v, '0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule